// File: doc/BRIEF.md
# Programmable Third-Order Decimation Filter

This block turns a one-bit oversampled bitstream from a sigma-delta modulator into wide signed conversion words. It uses a third-order cascaded integrator-comb filter. A clock-enable input marks each modulator sample. A 7-bit code sets how many samples make up one output word. Codes 0 to 125 give a ratio of (code+1)×64 samples, which is 8000/(code+1) words per second at a 512 kHz modulator rate. The two highest codes do not follow that rule. They select fixed ratios chosen for 60 Hz and 50 Hz mains rejection.

Loading a new code clears every integrator, comb delay and counter, so the filter starts again from an empty state. The comb delays are not meaningful until enough decimation points have passed. For that reason the data-valid strobe stays low for the first three decimation points after reset or after a configuration write. The strobe first fires at the fourth decimation point.

Top module: `sinc3_decim`

## Requirements
- R1: During and after reset the code is 7 (ratio 512), `dataValid` is low and `dataOut` is 0.
- R2: For a code `sf` from 0 to 125, one decimation point occurs every (sf+1)×64 accepted samples.
- R3: Code 126 uses a ratio of 8533 accepted samples.
- R4: Code 127 uses a ratio of 10240 accepted samples.
- R5: After reset or a configuration write, the first three decimation points produce no strobe. The first strobe marks decimation point 4, which falls at accepted sample 4×ratio.
- R6: A cycle with `cfgWrite` high loads `cfgSf`, discards any sample offered in that cycle, and clears all filter and counter state.
- R7: Input bit 1 counts as +1 and bit 0 counts as −1. A constant stream of ones gives ratio³, and a constant stream of zeros gives −ratio³.
- R8: The output is the third-order moving sum. A stream alternating 1,0 gives 0, and a repeating 1,1,1,0 stream gives ratio³/2 once settled.
- R9: A cycle with `sampleEn` low changes no filter state. Ratios count accepted samples, not clock cycles.
- R10: `dataValid` is a one-cycle pulse, and `dataOut` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Marks a cycle that carries a modulator sample |
| bitIn | input | 1 | Modulator bit (1 → +1, 0 → −1) |
| cfgWrite | input | 1 | Loads `cfgSf` and restarts the filter |
| cfgSf | input | 7 | Decimation code |
| dataOut | output | 43 | Signed conversion word, two's complement |
| dataValid | output | 1 | One-cycle strobe for a new word |

## Verification
A word's timing is measured in accepted samples counted from the restart. The strobe is visible in the cycle after the clock edge that takes accepted sample 4×ratio, and later strobes follow every ratio samples. The bench keeps its own count of accepted samples, excluding the configuration-write cycle. The driver queues the sample index at which each word is due, together with its value. On every strobe, at the falling edge, the monitor compares the running count and `dataOut` against the head of the queue. A half-rate enable run confirms that the timing follows samples rather than clock cycles.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef struct packed {
    logic clear;    // restart all state
    logic sample;   // accept one modulator sample
    logic decim;    // decimation point reached on this sample
    logic publish;  // decimation point past the settling window
  } strobe_t;
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int SF_W     = 7,
  parameter int BASE     = 64,
  parameter int RATIO_HI = 8533,
  parameter int RATIO_LO = 10240,
  parameter int RESET_SF = 7,
  parameter int SETTLE   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleEn,
  input  logic            cfgWrite,
  input  logic [SF_W-1:0] cfgSf,
  output strobe_t         strb
);
  localparam int CODE_HI = (1 << SF_W) - 2;
  localparam int CODE_LO = (1 << SF_W) - 1;
  localparam int MAX_LIN = CODE_HI * BASE;
  localparam int MAX_SP  = (RATIO_HI > RATIO_LO) ? RATIO_HI : RATIO_LO;
  localparam int MAX_R   = (MAX_LIN > MAX_SP) ? MAX_LIN : MAX_SP;
  localparam int CNT_W   = $clog2(MAX_R + 1);
  localparam int STL_W   = $clog2(SETTLE + 1);

  logic [SF_W-1:0]  sfReg;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] cnt;
  logic [STL_W-1:0] settleCnt;

  always_comb begin
    if (32'(sfReg) == CODE_HI)      ratio = CNT_W'(RATIO_HI);
    else if (32'(sfReg) == CODE_LO) ratio = CNT_W'(RATIO_LO);
    else                            ratio = CNT_W'((32'(sfReg) + 32'd1) * BASE);
  end

  always_comb begin
    strb.clear   = cfgWrite;
    strb.sample  = sampleEn && !cfgWrite;
    strb.decim   = strb.sample && (cnt == ratio - CNT_W'(1));
    strb.publish = strb.decim && (settleCnt == STL_W'(SETTLE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sfReg     <= SF_W'(RESET_SF);
      cnt       <= '0;
      settleCnt <= '0;
    end else if (cfgWrite) begin
      sfReg     <= cfgSf;
      cnt       <= '0;
      settleCnt <= '0;
    end else if (strb.sample) begin
      cnt <= strb.decim ? '0 : cnt + CNT_W'(1);
      if (strb.decim && settleCnt != STL_W'(SETTLE))
        settleCnt <= settleCnt + STL_W'(1);
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < ratio);
  assert_cfg_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (cnt == '0 && settleCnt == '0));
  assert_publish_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |=> !strb.publish);
endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 43,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic                    bitIn,
  output logic signed [ACC_W-1:0] dataOut,
  output logic                    dataValid
);
  logic signed [ACC_W-1:0] stepIn;
  logic signed [ACC_W-1:0] integ  [ORDER];
  logic signed [ACC_W-1:0] combDly[ORDER];
  logic signed [ACC_W-1:0] combVal[ORDER+1];

  assign stepIn     = bitIn ? ACC_W'(1) : -ACC_W'(1);
  assign combVal[0] = integ[ORDER-1];

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic signed [ACC_W-1:0] feed;
    if (i == 0) begin : g_first
      assign feed = stepIn;
    end else begin : g_rest
      assign feed = integ[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strb.clear)  integ[i] <= '0;
      else if (strb.sample)     integ[i] <= integ[i] + feed;
    end

    assign combVal[i+1] = combVal[i] - combDly[i];

    always_ff @(posedge clk) begin
      if (!rstN || strb.clear)  combDly[i] <= '0;
      else if (strb.decim)      combDly[i] <= combVal[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strb.publish;
      if (strb.publish) dataOut <= combVal[ORDER];
    end
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sample && !strb.clear) |=> $stable(integ[0]));
  assert_clear_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (integ[ORDER-1] == '0 && combDly[0] == '0));
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(dataOut));
  assert_valid_from_decim_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |=> dataValid);
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int SF_W  = 7,
  parameter int ACC_W = 43
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleEn,
  input  logic                    bitIn,
  input  logic                    cfgWrite,
  input  logic [SF_W-1:0]         cfgSf,
  output logic signed [ACC_W-1:0] dataOut,
  output logic                    dataValid
);
  strobe_t strb;

  sinc3_ctrl #(.SF_W(SF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .cfgWrite(cfgWrite), .cfgSf(cfgSf), .strb(strb)
  );

  sinc3_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn),
    .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: tb/sinc3_decim_tb.sv
module sinc3_decim_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic bitIn = 1'b0;
  logic cfgWrite = 1'b0;
  logic [6:0] cfgSf = 7'd0;
  logic signed [42:0] dataOut;
  logic dataValid;

  sinc3_decim u_dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .bitIn(bitIn),
    .cfgWrite(cfgWrite), .cfgSf(cfgSf), .dataOut(dataOut), .dataValid(dataValid)
  );

  always #2.5 clk = ~clk;

  typedef struct { longint idx; longint data; string tag; } item_t;
  item_t sb[$];

  int checks = 0;
  int fails = 0;
  longint enCount = 0;
  int pattern = 0;
  bit halfRate = 1'b0;
  bit prevValid = 1'b0;
  bit finished = 1'b0;

  function automatic logic patBit(int p, longint i);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      default: return (i % 4) != 3;
    endcase
  endfunction

  function automatic longint ratioOf(int sf);
    if (sf == 126) return 8533;
    if (sf == 127) return 10240;
    return longint'(sf + 1) * 64;
  endfunction

  function automatic longint expData(int p, longint r);
    case (p)
      0: return r * r * r;
      1: return -(r * r * r);
      2: return 0;
      default: return (r * r * r) / 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // accepted samples since restart (config-write cycle excluded)
  always @(posedge clk) begin
    if (!rstN || cfgWrite) enCount <= 0;
    else if (sampleEn) enCount <= enCount + 1;
  end

  // stimulus stream, driven away from the edge
  always @(posedge clk) begin
    #1;
    bitIn = patBit(pattern, enCount);
    sampleEn = halfRate ? ~sampleEn : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) begin
        check(!prevValid, "R10 pulse width", longint'(prevValid), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected strobe", enCount, -1);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(enCount == it.idx, {it.tag, " timing"}, enCount, it.idx);
          check(longint'(dataOut) == it.data, {it.tag, " data"}, longint'(dataOut), it.data);
        end
      end
      prevValid = dataValid;
    end else begin
      prevValid = 1'b0;
    end
  end

  task automatic pushItems(int sf, int p, int n, string tag);
    longint r = ratioOf(sf);
    for (int k = 4; k < 4 + n; k++) begin
      item_t it;
      it.idx = k * r;
      it.data = expData(p, r);
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic writeCfg(int sf);
    @(posedge clk); #1;
    cfgWrite = 1'b1; cfgSf = 7'(sf);
    @(posedge clk); #1;
    cfgWrite = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runCase(int sf, int p, bit half, int n, string tag);
    pattern = p;
    halfRate = half;
    writeCfg(sf);
    pushItems(sf, p, n, tag);
    drain();
  endtask

  task automatic finish();
    check(sb.size() == 0, "R5 missing strobes", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000 - 5000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      finish();
    end
  end

  initial begin
    pattern = 0;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(dataValid == 1'b0, "R1 valid in reset", longint'(dataValid), 0);
    check(dataOut == '0, "R1 data in reset", longint'(dataOut), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    // R1/R5/R7: default code 7 gives ratio 512, first strobe at 4*512
    pushItems(7, 0, 2, "R1 default ratio");
    drain();
    check(dataValid == 1'b0, "R10 strobe low between words", longint'(dataValid), 0);

    runCase(0, 0, 1'b0, 3, "R2 R7 ones sf0");
    runCase(0, 1, 1'b0, 2, "R7 zeros sf0");
    runCase(3, 2, 1'b0, 2, "R8 alternating sf3");
    runCase(1, 3, 1'b0, 2, "R8 three-quarter sf1");
    runCase(0, 0, 1'b1, 2, "R9 half-rate enable");

    // R6: restart mid-run; no stale strobe may appear
    pattern = 0; halfRate = 1'b0;
    writeCfg(0);
    repeat (100) @(posedge clk);
    runCase(1, 1, 1'b0, 2, "R6 restart");

    runCase(125, 0, 1'b0, 1, "R2 top linear code");
    runCase(126, 0, 1'b0, 2, "R3 code 126");
    runCase(127, 0, 1'b0, 1, "R4 code 127");

    finished = 1'b1;
    finish();
  end
endmodule